// File: doc/BRIEF.md
# FPR/GPR Transfer Unit

This execution unit moves operands between the floating-point register port and the integer register port without doing any arithmetic. It handles four operations: a raw 64-bit copy in each direction, a narrowing move that repacks a double-format register image as a 32-bit single-format word for the integer side, and a widening move that expands a single-format word from the integer side into the double-format register image. No floating-point status or exception flag is read or written by any of them.

Moves toward the integer side may ask for a record form. This produces a four-bit condition field from the 64-bit result, using the same signed rule as ordinary fixed-point operations, together with a write enable for that field. Requests enter through a valid/ready port and results leave through a valid/ready port. There is a single pipeline register between the two ports. A request is taken on a rising clock edge when `in_valid` and `in_ready` are both high. While a held result is not taken (`out_valid` high and `out_ready` low), `in_ready` is low and the held result does not change.

Top module: `fpr_gpr_xfer`

## Requirements
- R1: Opcode 0 (raw move toward the integer side) returns all 64 source bits unchanged.
- R2: Opcode 1 (raw move toward the FP side) returns all 64 source bits unchanged. The condition write enable stays low.
- R3: Opcode 2 (narrow) applied to a source with biased double exponent e ≥ 897 (this covers Inf and NaN) yields the 32-bit word {src[63], src[62], src[58:29]}.
- R4: Opcode 2 applied to a source with 874 ≤ e ≤ 896 yields {sign, eight zero bits, low 23 bits of ({1, src[51:29]} >> (897 − e))}.
- R5: Opcode 2 applied to a source with e ≤ 873 (this covers zero and double subnormals) yields a signed zero: {src[63], 31 zero bits}.
- R6: Every narrow result has bits 63:32 equal to zero.
- R7: Opcode 3 (widen) reads only src[31:0] as sign s, exponent x (bits 30:23) and fraction f (bits 22:0). When 1 ≤ x ≤ 254 the result is {s, x+896, f, 29 zeros}. When x = 255 the result is {s, 11'h7FF, f, 29 zeros}, so NaN payloads are kept. The upper 32 source bits have no effect.
- R8: Opcode 3 with x = 0 yields signed zero when f = 0. When f ≠ 0 it yields the exact double normal number: with z the count of leading zeros of f, the exponent is 896 − z and the fraction is (f << (z+1)) in the top 23 bits followed by 29 zeros.
- R9: The condition field is out_cr = {LT, GT, EQ, SO} (bit 3 = LT). LT, GT and EQ come from a signed comparison of the 64-bit result with zero. out_cr_we is high only for opcode 0 or 2 with the record flag set. Otherwise out_cr_we is low and out_cr is zero.
- R10: SO equals the in_so value sampled when the request was taken.
- R11: After synchronous reset out_valid is low. A taken request shows its result with out_valid high on the next clock edge.
- R12: While out_valid is high and out_ready is low, in_ready is low, and out_data, out_cr and out_cr_we hold. Otherwise in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_op | input | 2 | 0 raw to int, 1 raw to FP, 2 narrow to int, 3 widen to FP |
| in_rec | input | 1 | Record form: produce the condition field |
| in_data | input | 64 | Source operand |
| in_so | input | 1 | Summary-overflow bit copied into the condition field |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 64 | Result |
| out_cr | output | 4 | Condition field {LT, GT, EQ, SO} |
| out_cr_we | output | 1 | Condition field write enable |

## Verification
The hardest cases to reach are the narrowing boundaries and the widening subnormals. Random 64-bit patterns almost never produce a double exponent between 874 and 896, and almost never a single-format word whose exponent field is zero. The stimulus therefore builds operands from a chosen sign, exponent and fraction. Exponents are drawn in clusters around 873/874, 896/897 and the single-format overflow edge, and widening operands get zero exponents with sparse fractions, so that every leading-zero count is used. Back-pressure is applied by toggling out_ready at random in some phases, so that results are held while new requests wait.

// File: rtl/xfer_pkg.sv
`timescale 1ns/1ps
package xfer_pkg;
  localparam int XW       = 64;
  localparam int SW       = 32;
  localparam int D_EW     = 11;
  localparam int D_FW     = 52;
  localparam int S_EW     = 8;
  localparam int S_FW     = 23;
  localparam int BIAS_GAP = 896;              // double bias minus single bias
  localparam int PAD_W    = D_FW - S_FW;      // 29 fraction bits dropped/added
  localparam int SUB_SPAN = S_FW;             // exponents with a subnormal image
  localparam int LZ_W     = $clog2(S_FW + 1);

  typedef enum logic [1:0] {
    OP_RAW_TO_INT = 2'd0,
    OP_RAW_TO_FP  = 2'd1,
    OP_NARROW     = 2'd2,
    OP_WIDEN      = 2'd3
  } xop_e;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } crf_t;
endpackage

// File: rtl/xfer_narrow.sv
`timescale 1ns/1ps
module xfer_narrow
  import xfer_pkg::*;
(
  input  logic [XW-1:0] dbl,
  output logic [SW-1:0] sgl
);
  localparam logic [D_EW-1:0] E_NORM_MIN = D_EW'(BIAS_GAP + 1);
  localparam logic [D_EW-1:0] E_SUB_MIN  = D_EW'(BIAS_GAP + 1 - SUB_SPAN);

  logic              sgn;
  logic [D_EW-1:0]   dexp;
  logic [S_FW:0]     sig;
  logic [D_EW-1:0]   deficit;
  logic [S_FW:0]     shifted;
  logic [SW-1:0]     bit_pick;

  assign sgn      = dbl[XW-1];
  assign dexp     = dbl[XW-2 -: D_EW];
  assign sig      = {1'b1, dbl[D_FW-1 -: S_FW]};
  assign deficit  = E_NORM_MIN - dexp;
  assign shifted  = sig >> deficit[LZ_W-1:0];
  // sign, exponent MSB, low exponent bits and top fraction bits
  assign bit_pick = {dbl[XW-1], dbl[XW-2], dbl[XW-2-(D_EW-S_EW+1) -: (SW-2)]};

  always_comb begin
    if (dexp >= E_NORM_MIN)
      sgl = bit_pick;
    else if (dexp >= E_SUB_MIN)
      sgl = {sgn, {S_EW{1'b0}}, shifted[S_FW-1:0]};
    else
      sgl = {sgn, {(SW-1){1'b0}}};
  end
endmodule

// File: rtl/xfer_widen.sv
`timescale 1ns/1ps
module xfer_widen
  import xfer_pkg::*;
(
  input  logic [SW-1:0] sgl,
  output logic [XW-1:0] dbl
);
  logic              sgn;
  logic [S_EW-1:0]   sexp;
  logic [S_FW-1:0]   frac;
  logic [LZ_W-1:0]   lz;
  logic              seen;
  logic [S_FW-1:0]   norm_frac;
  logic [D_EW-1:0]   norm_exp;
  logic [D_EW-1:0]   rebias_exp;

  assign sgn  = sgl[SW-1];
  assign sexp = sgl[SW-2 -: S_EW];
  assign frac = sgl[S_FW-1:0];

  always_comb begin
    lz   = '0;
    seen = 1'b0;
    for (int i = S_FW - 1; i >= 0; i--) begin
      if (!seen) begin
        if (frac[i]) seen = 1'b1;
        else         lz   = lz + 1'b1;
      end
    end
  end

  assign norm_frac  = frac << (lz + 1'b1);
  assign norm_exp   = D_EW'(BIAS_GAP) - D_EW'(lz);
  assign rebias_exp = D_EW'(BIAS_GAP) + D_EW'(sexp);

  always_comb begin
    if (sexp == {S_EW{1'b1}})
      dbl = {sgn, {D_EW{1'b1}}, frac, {PAD_W{1'b0}}};
    else if (sexp != '0)
      dbl = {sgn, rebias_exp, frac, {PAD_W{1'b0}}};
    else if (frac == '0)
      dbl = {sgn, {(XW-1){1'b0}}};
    else
      dbl = {sgn, norm_exp, norm_frac, {PAD_W{1'b0}}};
  end
endmodule

// File: rtl/xfer_crgen.sv
`timescale 1ns/1ps
module xfer_crgen
  import xfer_pkg::*;
(
  input  logic [XW-1:0] res,
  input  logic          so,
  output crf_t          crf
);
  logic is_zero;
  assign is_zero = (res == '0);
  always_comb begin
    crf.lt = res[XW-1];
    crf.gt = !res[XW-1] && !is_zero;
    crf.eq = is_zero;
    crf.so = so;
  end
endmodule

// File: rtl/fpr_gpr_xfer.sv
`timescale 1ns/1ps
module fpr_gpr_xfer
  import xfer_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_op,
  input  logic          in_rec,
  input  logic [63:0]   in_data,
  input  logic          in_so,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [63:0]   out_data,
  output logic [3:0]    out_cr,
  output logic          out_cr_we
);
  xop_e           op;
  logic           take;
  logic [SW-1:0]  narrow_w;
  logic [XW-1:0]  widen_d;
  logic [XW-1:0]  result;
  logic           to_int;
  crf_t           crf;

  assign op       = xop_e'(in_op);
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;
  assign to_int   = (op == OP_RAW_TO_INT) || (op == OP_NARROW);

  xfer_narrow u_narrow (.dbl(in_data), .sgl(narrow_w));
  xfer_widen  u_widen  (.sgl(in_data[SW-1:0]), .dbl(widen_d));

  always_comb begin
    unique case (op)
      OP_NARROW: result = {{(XW-SW){1'b0}}, narrow_w};
      OP_WIDEN:  result = widen_d;
      default:   result = in_data;
    endcase
  end

  xfer_crgen u_crgen (.res(result), .so(in_so), .crf(crf));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_cr    <= '0;
      out_cr_we <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= result;
      out_cr_we <= to_int && in_rec;
      out_cr    <= (to_int && in_rec) ? crf : '0;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/xfer_chk.sv
`timescale 1ns/1ps
module xfer_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic [1:0]  in_op,
  input logic        in_rec,
  input logic [63:0] in_data,
  input logic        in_so,
  input logic        out_valid,
  input logic        out_ready,
  input logic [63:0] out_data,
  input logic [3:0]  out_cr,
  input logic        out_cr_we
);
  logic take;
  assign take = in_valid && in_ready;

  AST_RAW_COPY: assert property (@(posedge clk) disable iff (rst)
    take && !in_op[1] |=> out_data == $past(in_data)); // R1
  AST_RAW_IN_NO_CR: assert property (@(posedge clk) disable iff (rst)
    take && in_op == 2'd1 |=> !out_cr_we); // R2
  AST_NARROW_ZEXT: assert property (@(posedge clk) disable iff (rst)
    take && in_op == 2'd2 |=> out_data[63:32] == 32'd0); // R6
  AST_WIDEN_SPECIAL: assert property (@(posedge clk) disable iff (rst)
    take && in_op == 2'd3 && in_data[30:23] == 8'hFF
    |=> out_data[62:52] == 11'h7FF && out_data[51:29] == $past(in_data[22:0])); // R7
  AST_WIDEN_SIGN: assert property (@(posedge clk) disable iff (rst)
    take && in_op == 2'd3 |=> out_data[63] == $past(in_data[31])); // R8
  AST_CR_EQ: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_cr_we |-> out_cr[1] == (out_data == 64'd0)); // R9
  AST_CR_LT: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_cr_we |-> out_cr[3] == out_data[63]); // R9
  AST_CR_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_cr_we |-> $onehot0(out_cr[3:1]) && out_cr[3:1] != 3'b0); // R9
  AST_CR_WE_SRC: assert property (@(posedge clk) disable iff (rst)
    take |=> out_cr_we == $past(in_rec && !in_op[0])); // R9
  AST_SO_COPY: assert property (@(posedge clk) disable iff (rst)
    take && in_rec && !in_op[0] |=> out_cr[0] == $past(in_so)); // R10
  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (rst)
    take |=> out_valid); // R11
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_cr)
    && $stable(out_cr_we)); // R12
  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready); // R12
endmodule

bind fpr_gpr_xfer xfer_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_rec(in_rec), .in_data(in_data), .in_so(in_so),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_cr(out_cr), .out_cr_we(out_cr_we)
);

// File: tb/fpr_gpr_xfer_tb.sv
`timescale 1ns/1ps
module fpr_gpr_xfer_tb;
  logic        clk = 0;
  logic        rst = 1;
  logic        in_valid = 0;
  logic        in_ready;
  logic [1:0]  in_op = 0;
  logic        in_rec = 0;
  logic [63:0] in_data = 0;
  logic        in_so = 0;
  logic        out_valid;
  logic        out_ready = 1;
  logic [63:0] out_data;
  logic [3:0]  out_cr;
  logic        out_cr_we;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  bit rand_ready = 0;

  always #2.5 clk = ~clk;

  fpr_gpr_xfer u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_rec(in_rec), .in_data(in_data), .in_so(in_so),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_cr(out_cr), .out_cr_we(out_cr_we)
  );

  // ---------------- behavioural reference ----------------
  function automatic logic [63:0] ref_narrow(input logic [63:0] d);
    int e;
    logic [31:0] m;
    e = int'(d[62:52]);
    if (e >= 897) return {32'd0, d[63], d[62], d[58:29]};
    if (e >= 874) begin
      m = {8'd0, 1'b1, d[51:29]};
      for (int k = e; k < 897; k++) m = m / 2;
      return {32'd0, d[63], 8'd0, m[22:0]};
    end
    return {32'd0, d[63], 31'd0};
  endfunction

  function automatic logic [63:0] ref_widen(input logic [63:0] src);
    logic [31:0] w;
    int x, ex;
    logic [23:0] m;
    w = src[31:0];
    x = int'(w[30:23]);
    if (x == 255) return {w[31], 11'h7FF, w[22:0], 29'd0};
    if (x != 0)   return {w[31], 11'(x + 896), w[22:0], 29'd0};
    if (w[22:0] == 0) return {w[31], 63'd0};
    m = {1'b0, w[22:0]};
    ex = 897;
    while (!m[23]) begin m = m * 2; ex = ex - 1; end
    return {w[31], 11'(ex), m[22:0], 29'd0};
  endfunction

  function automatic string tag_of(input logic [1:0] op, input logic [63:0] d);
    int e;
    e = int'(d[62:52]);
    case (op)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return (e >= 897) ? "R3" : (e >= 874) ? "R4" : "R5";
      default: return (d[30:23] == 0) ? "R8" : "R7";
    endcase
  endfunction

  bit          m_valid = 0;
  logic [63:0] m_data = 0;
  logic [3:0]  m_cr = 0;
  bit          m_we = 0;
  bit          m_narrow = 0;
  string       m_tag = "R11";
  bit          m_acc = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    m_acc = in_valid && (!m_valid || out_ready) && !rst;
    if (rst) begin
      m_valid = 0; m_data = 0; m_cr = 0; m_we = 0;
    end else if (m_acc) begin
      m_valid = 1;
      m_tag   = tag_of(in_op, in_data);
      m_narrow = (in_op == 2'd2);
      case (in_op)
        2'd2: m_data = ref_narrow(in_data);
        2'd3: m_data = ref_widen(in_data);
        default: m_data = in_data;
      endcase
      m_we = in_rec && (in_op == 2'd0 || in_op == 2'd2);
      if (m_we) begin
        m_cr[3] = $signed(m_data) < 0;
        m_cr[2] = $signed(m_data) > 0;
        m_cr[1] = m_data == 0;
        m_cr[0] = in_so;
      end else m_cr = 0;
    end else if (out_ready) m_valid = 0;
    #1;
    if (!rst) begin
      chk(out_valid == m_valid, "R11", "out_valid", 64'(out_valid), 64'(m_valid));
      chk(in_ready == (!m_valid || out_ready), "R12", "in_ready", 64'(in_ready),
          64'(!m_valid || out_ready));
      if (m_valid) begin
        chk(out_data == m_data, m_tag, "out_data", out_data, m_data);
        if (m_narrow) chk(out_data[63:32] == 0, "R6", "upper half", out_data, m_data);
        chk(out_cr_we == m_we, "R9", "out_cr_we", 64'(out_cr_we), 64'(m_we));
        chk(out_cr[3:1] == m_cr[3:1], "R9", "LT/GT/EQ", 64'(out_cr), 64'(m_cr));
        chk(out_cr[0] == m_cr[0], "R10", "SO", 64'(out_cr), 64'(m_cr));
      end
    end
  end

  always @(negedge clk) out_ready <= rand_ready ? ($urandom % 3 != 0) : 1'b1;

  // ---------------- stimulus ----------------
  task automatic send(input logic [1:0] op, input bit rec, input logic [63:0] d, input bit so);
    @(negedge clk);
    in_valid = 1; in_op = op; in_rec = rec; in_data = d; in_so = so;
    do begin @(posedge clk); #1; end while (!m_acc);
  endtask

  function automatic logic [63:0] mkd(input bit s, input int e, input logic [51:0] f);
    return {s, 11'(e), f};
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    repeat (4) @(posedge clk);
    #1;
    chk(out_valid == 0, "R11", "reset valid", 64'(out_valid), 0);
    chk(out_cr_we == 0, "R11", "reset cr_we", 64'(out_cr_we), 0);
    @(negedge clk); rst = 0;
    #0.5;
    chk(in_ready == 1, "R12", "reset ready", 64'(in_ready), 1);

    // directed corners
    send(2'd0, 1, 64'h8000_0000_0000_0001, 1);       // R1 negative, SO
    send(2'd0, 1, 64'd0, 0);                           // R1 EQ
    send(2'd1, 1, 64'hDEAD_BEEF_0123_4567, 1);        // R2 record ignored
    send(2'd2, 1, 64'h3FF0_0000_0000_0000, 0);        // R3 1.0
    send(2'd2, 0, 64'h7FF0_0000_0000_0000, 0);        // R3 inf
    send(2'd2, 0, 64'hFFF8_0000_0000_1234, 0);        // R3 NaN
    send(2'd2, 1, mkd(0, 896, 52'hF_FFFF_FFFF_FFFF), 0); // R4 top edge
    send(2'd2, 1, mkd(1, 874, 52'h8_0000_0000_0000), 1); // R4 bottom edge
    send(2'd2, 1, mkd(1, 873, 52'hF_FFFF_FFFF_FFFF), 0); // R5
    send(2'd2, 1, 64'h0000_0000_0000_0001, 0);        // R5 double subnormal
    send(2'd3, 0, 64'hFFFF_FFFF_3F80_0000, 0);        // R7 upper ignored
    send(2'd3, 0, 64'h0000_0000_7FC0_0001, 0);        // R7 NaN payload
    send(2'd3, 0, 64'h0000_0000_8000_0000, 0);        // R8 -0
    send(2'd3, 0, 64'h0000_0000_0000_0001, 0);        // R8 smallest
    send(2'd3, 0, 64'h1234_5678_0040_0000, 0);        // R8 largest lz=0

    // every leading-zero count on widening
    for (int z = 0; z < 23; z++) send(2'd3, 0, {32'd0, 1'($urandom), 8'd0, 23'(1 << (22 - z))}, 0);

    // clustered random with back-pressure
    rand_ready = 1;
    for (int n = 0; n < 600; n++) begin
      logic [1:0] op;
      logic [63:0] d;
      int pick;
      op = 2'($urandom);
      d = rnd64();
      pick = $urandom % 6;
      if (op == 2'd2) begin
        case (pick)
          0: d = mkd(1'($urandom), 870 + $urandom % 32, d[51:0]);
          1: d = mkd(1'($urandom), 1145 + $urandom % 10, d[51:0]);
          2: d = mkd(1'($urandom), ($urandom % 2) ? 2047 : 0, d[51:0]);
          default: ;
        endcase
      end else if (op == 2'd3 && pick < 3) begin
        d[30:23] = (pick == 0) ? 8'hFF : 8'h00;
        if (pick == 2) d[22:0] = 23'($urandom) >> ($urandom % 23);
      end
      send(op, 1'($urandom), d, 1'($urandom));
    end
    @(negedge clk); in_valid = 0;
    rand_ready = 0;
    repeat (5) @(posedge clk);
    #2;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL R11 watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule